// File: doc/BRIEF.md
# PWM Sample Queue with Entry Reordering

This block buffers compare samples for a pulse-width modulator. A producer presents a 32-bit word. The block takes one 16-bit half of that word, can reverse the two bytes of that half, and stores the result in a four-deep first-in first-out queue. The PWM core asks for the next compare value by pulsing a request. The block then moves the oldest stored sample into a held output register. That register keeps its value until the next successful pop.

A seven-bit status word reports three things: the number of stored samples, a level flag that shows when enough free slots exist for the producer to refill, and three sticky event flags. One of these records writes that were dropped because the queue was full. The other two latch rollover and compare events from the PWM core. Software clears the sticky flags by writing ones to them. A synchronous soft reset returns the whole block to its reset state.

The write side uses valid/ready. `in_ready` is high whenever the queue is not full. The producer should hold `in_valid` until it sees `in_ready`. A word offered while `in_ready` is low is not stored and is not kept for a later cycle: it is discarded and logged as a write error. The consumer side and all control pins are plain signals.

Top module: `pwm_sample_fifo`

## Requirements
- R1: The queue holds up to 4 samples of 16 bits and returns them in the order they were written. `in_ready` is 1 exactly when fewer than 4 samples are stored, and a push happens when `in_valid` and `in_ready` are both 1.
- R2: `status[2:0]` gives the stored count (0 to 4) and is updated on the clock edge that performs a push or a pop.
- R3: `status[3]` is a level flag. It is 1 exactly when (4 - count) >= `wm_code` + 1. The codes 0, 1, 2 and 3 select thresholds of 1, 2, 3 and 4 free slots, and code 1 is the intended default. Writing 1 to this bit has no effect.
- R4: With `hswap`=0 the sample is taken from `in_data[15:0]`; with `hswap`=1 it is taken from `in_data[31:16]`.
- R5: With `bswap`=1 the two bytes of the selected half are exchanged before the sample is stored; with `bswap`=0 they pass unchanged.
- R6: A word offered while 4 samples are stored is dropped. The stored samples and the count do not change, and the sticky write-error flag `status[6]` is set on the next edge.
- R7: A pulse on `roll_evt` sets the sticky flag `status[4]`, and a pulse on `cmp_evt` sets the sticky flag `status[5]`.
- R8: When `clr_valid` is 1, each of `status[6:4]` whose bit in `clr_mask` is 1 is cleared on the next edge. If a set event occurs in the same cycle, the set wins.
- R9: A push and a pop in the same cycle with 1 to 3 samples stored leave the count unchanged.
- R10: A pop request while the queue is empty leaves `sample_q` unchanged.
- R11: A pop with at least one sample stored loads the oldest sample into `sample_q` on that edge and removes it from the queue.
- R12: `soft_rst`=1 clears the queue, the sticky flags and `sample_q` on the next edge, and blocks any push in that cycle. The asynchronous `rst_n` has the same effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous reset of queue, flags and output |
| in_valid | input | 1 | Write word is offered |
| in_ready | output | 1 | Queue can accept a word |
| in_data | input | 32 | Write word |
| hswap | input | 1 | 0: low half is used, 1: high half is used |
| bswap | input | 1 | Exchange the bytes of the selected half |
| wm_code | input | 2 | Free-slot threshold minus one |
| pop_req | input | 1 | PWM core requests the next sample |
| sample_q | output | 16 | Current compare sample |
| roll_evt | input | 1 | Rollover event pulse |
| cmp_evt | input | 1 | Compare event pulse |
| clr_valid | input | 1 | Write-one-to-clear strobe |
| clr_mask | input | 7 | Bits to clear, aligned with status |
| status | output | 7 | [2:0] count, [3] level flag, [4] rollover, [5] compare, [6] write error |

## Verification
The assertions assume that inputs change only between clock edges and that `soft_rst` is the only synchronous path that discards state. They make no assumption about the producer respecting `in_ready`, because writes to a full queue are defined behaviour here. The bench drives every input half a period after an edge and deliberately offers words to a full queue. It also sweeps every watermark code against every fill level and every swap combination against asymmetric data words, so that a wrong half or a missing byte exchange shows up in the output.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  localparam int SAMPLE_W = 16;
  localparam int WORD_W   = 32;
  localparam int Q_DEPTH  = 4;
  localparam int CNT_W    = $clog2(Q_DEPTH + 1);
  localparam int WM_W     = 2;
  localparam int STAT_W   = 7;
  // status bit positions
  localparam int ST_LVL   = 3;
  localparam int ST_ROLL  = 4;
  localparam int ST_CMP   = 5;
  localparam int ST_WERR  = 6;
endpackage

// File: rtl/pfs_entry_swap.sv
module pfs_entry_swap #(
  parameter int WORD_W   = 32,
  parameter int SAMPLE_W = 16
) (
  input  logic [WORD_W-1:0]   word,
  input  logic                hswap,
  input  logic                bswap,
  output logic [SAMPLE_W-1:0] sample
);
  localparam int NBYTES = SAMPLE_W / 8;

  logic [SAMPLE_W-1:0] half;
  logic [SAMPLE_W-1:0] flipped;

  assign half = hswap ? word[2*SAMPLE_W-1:SAMPLE_W] : word[SAMPLE_W-1:0];

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign flipped[b*8 +: 8] = half[(NBYTES-1-b)*8 +: 8];
  end

  assign sample = bswap ? flipped : half;
endmodule

// File: rtl/pfs_queue.sv
module pfs_queue #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       push,
  input  logic                       pop,
  input  logic [W-1:0]               din,
  output logic [W-1:0]               head,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH+1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + PTR_W'(1);
      if (pop)  rd_ptr <= rd_ptr + PTR_W'(1);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   mem[i] <= '0;
      else if (push && !clr && wr_ptr == PTR_W'(i)) mem[i] <= din;
    end
  end

  assign head = mem[rd_ptr];
endmodule

// File: rtl/pfs_flags.sv
module pfs_flags #(
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 3,
  parameter int WM_W   = 2,
  parameter int STAT_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [CNT_W-1:0]  count,
  input  logic [WM_W-1:0]   wm_code,
  input  logic              werr_evt,
  input  logic              roll_evt,
  input  logic              cmp_evt,
  input  logic              clr_valid,
  input  logic [STAT_W-1:0] clr_mask,
  output logic [STAT_W-1:0] status
);
  import pfs_pkg::*;

  logic [CNT_W:0] free_slots;
  logic [CNT_W:0] need;
  logic           lvl;
  logic [2:0]     sticky_q;
  logic [2:0]     set_v, clr_v;

  assign free_slots = (CNT_W+1)'(DEPTH) - {1'b0, count};
  assign need       = (CNT_W+1)'(wm_code) + (CNT_W+1)'(1);
  assign lvl        = free_slots >= need;

  assign set_v = {werr_evt, cmp_evt, roll_evt};
  assign clr_v = clr_valid ? clr_mask[ST_WERR:ST_ROLL] : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sticky_q <= '0;
    else if (clr) sticky_q <= '0;
    else          sticky_q <= set_v | (sticky_q & ~clr_v);
  end

  always_comb begin
    status                   = '0;
    status[CNT_W-1:0]        = count;
    status[ST_LVL]           = lvl;
    status[ST_WERR:ST_ROLL]  = sticky_q;
  end
endmodule

// File: rtl/pwm_sample_fifo.sv
module pwm_sample_fifo
  import pfs_pkg::*;
#(
  parameter int DEPTH = Q_DEPTH
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                soft_rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [WORD_W-1:0]   in_data,
  input  logic                hswap,
  input  logic                bswap,
  input  logic [WM_W-1:0]     wm_code,
  input  logic                pop_req,
  output logic [SAMPLE_W-1:0] sample_q,
  input  logic                roll_evt,
  input  logic                cmp_evt,
  input  logic                clr_valid,
  input  logic [STAT_W-1:0]   clr_mask,
  output logic [STAT_W-1:0]   status
);
  localparam int CW = $clog2(DEPTH+1);

  logic [SAMPLE_W-1:0] entry;
  logic [SAMPLE_W-1:0] head;
  logic [CW-1:0]       count;
  logic                full, empty, push, pop, werr;

  assign full     = count == CW'(DEPTH);
  assign empty    = count == '0;
  assign in_ready = !full;
  assign push     = in_valid && !full && !soft_rst;
  assign pop      = pop_req && !empty && !soft_rst;
  assign werr     = in_valid && full && !soft_rst;

  pfs_entry_swap #(.WORD_W(WORD_W), .SAMPLE_W(SAMPLE_W)) u_swap (
    .word(in_data), .hswap(hswap), .bswap(bswap), .sample(entry)
  );

  pfs_queue #(.W(SAMPLE_W), .DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .push(push), .pop(pop),
    .din(entry), .head(head), .count(count)
  );

  pfs_flags #(.DEPTH(DEPTH), .CNT_W(CW), .WM_W(WM_W), .STAT_W(STAT_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .count(count), .wm_code(wm_code),
    .werr_evt(werr), .roll_evt(roll_evt), .cmp_evt(cmp_evt),
    .clr_valid(clr_valid), .clr_mask(clr_mask), .status(status)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sample_q <= '0;
    else if (soft_rst) sample_q <= '0;
    else if (pop)      sample_q <= head;
  end
endmodule

// File: rtl/pwm_sample_fifo_chk.sv
module pwm_sample_fifo_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        soft_rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic        pop_req,
  input logic        roll_evt,
  input logic        cmp_evt,
  input logic        clr_valid,
  input logic [6:0]  clr_mask,
  input logic [15:0] sample_q,
  input logic [6:0]  status
);
  assert_count_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    status[2:0] <= 3'd4);

  assert_ready_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == (status[2:0] != 3'd4));

  assert_drop_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && !pop_req && !soft_rst) |=> status[2:0] == 3'd4);

  assert_werr_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && !soft_rst) |=> status[6]);

  assert_event_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (roll_evt && !soft_rst) |=> status[4]);

  assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_valid && clr_mask[5] && !cmp_evt) |=> !status[5]);

  assert_pushpop_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && pop_req && status[2:0] != 3'd0 && !soft_rst) |=> $stable(status[2:0]));

  assert_empty_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && status[2:0] == 3'd0 && !soft_rst) |=> $stable(sample_q));

  assert_soft_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (status[2:0] == 3'd0 && status[6:4] == 3'd0 && sample_q == 16'h0));
endmodule

bind pwm_sample_fifo pwm_sample_fifo_chk u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .in_valid(in_valid),
  .in_ready(in_ready), .pop_req(pop_req), .roll_evt(roll_evt), .cmp_evt(cmp_evt),
  .clr_valid(clr_valid), .clr_mask(clr_mask), .sample_q(sample_q), .status(status)
);

// File: tb/test_pwm_sample_fifo.sv
`timescale 1ns/1ps
module test_pwm_sample_fifo;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        soft_rst = 0, in_valid = 0, hswap = 0, bswap = 0, pop_req = 0;
  logic        roll_evt = 0, cmp_evt = 0, clr_valid = 0;
  logic [31:0] in_data = '0;
  logic [1:0]  wm_code = 2'd1;
  logic [6:0]  clr_mask = '0;
  logic        in_ready;
  logic [15:0] sample_q;
  logic [6:0]  status;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwm_sample_fifo i_pwm_sample_fifo (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .hswap(hswap), .bswap(bswap),
    .wm_code(wm_code), .pop_req(pop_req), .sample_q(sample_q),
    .roll_evt(roll_evt), .cmp_evt(cmp_evt), .clr_valid(clr_valid),
    .clr_mask(clr_mask), .status(status)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one clock edge; inputs are driven and outputs sampled at the falling edge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push(input logic [31:0] d, input logic hs, input logic bs);
    in_valid = 1; in_data = d; hswap = hs; bswap = bs;
    tick();
    in_valid = 0;
  endtask

  task automatic pop();
    pop_req = 1;
    tick();
    pop_req = 0;
  endtask

  function automatic logic [15:0] exp_entry(input logic [31:0] d, input logic hs, input logic bs);
    logic [15:0] h;
    h = hs ? d[31:16] : d[15:0];
    return bs ? {h[7:0], h[15:8]} : h;
  endfunction

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] q [4];
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    check("R2 reset count", {25'd0, status}, {25'd0, 7'b0001000});
    check("R1 reset ready", {31'd0, in_ready}, 32'd1);
    check("R12 reset sample", {16'd0, sample_q}, 32'd0);

    // R4/R5 sweep over swap combinations
    for (int k = 0; k < 4; k++) begin
      logic [31:0] d;
      d = 32'hA1B2C3D4 + 32'h01010101 * k;
      push(d, k[1], k[0]);
      pop();
      check($sformatf("R4 R5 swap hs=%0d bs=%0d", k[1], k[0]), {16'd0, sample_q},
            {16'd0, exp_entry(d, k[1], k[0])});
    end

    // R2/R3 sweep: fill level vs every watermark code, with order check R1/R11
    for (int n = 0; n <= 4; n++) begin
      for (int w = 0; w < 4; w++) begin
        wm_code = w[1:0];
        #1;
        check($sformatf("R3 lvl n=%0d wm=%0d", n, w), {31'd0, status[3]},
              {31'd0, ((4 - n) >= (w + 1))});
      end
      check($sformatf("R2 count n=%0d", n), {29'd0, status[2:0]}, n);
      check($sformatf("R1 ready n=%0d", n), {31'd0, in_ready}, {31'd0, n < 4});
      if (n < 4) begin
        q[n] = 16'h1000 + 16'h0111 * n;
        push({16'h0, q[n]}, 0, 0);
      end
    end
    wm_code = 2'd1;
    // R3: writing one to the level bit does not clear it (count 4, wm=0 -> free 0, flag 0; use empty later)
    // R6 overflow
    check("R6 werr clear before", {31'd0, status[6]}, 32'd0);
    push(32'h0000DEAD, 0, 0);
    check("R6 count unchanged", {29'd0, status[2:0]}, 32'd4);
    check("R6 werr set", {31'd0, status[6]}, 32'd1);
    // R8 clear error
    clr_valid = 1; clr_mask = 7'b1000000;
    tick();
    clr_valid = 0; clr_mask = '0;
    check("R8 werr cleared", {31'd0, status[6]}, 32'd0);
    // R1/R11 ordering, and R6 contents unchanged
    for (int n = 0; n < 4; n++) begin
      pop();
      check($sformatf("R11 order %0d", n), {16'd0, sample_q}, {16'd0, q[n]});
    end
    check("R2 drained", {29'd0, status[2:0]}, 32'd0);
    // R10 pop on empty
    pop();
    check("R10 empty pop holds", {16'd0, sample_q}, {16'd0, q[3]});
    // R3 write one to level bit has no effect
    clr_valid = 1; clr_mask = 7'b0001000;
    tick();
    clr_valid = 0; clr_mask = '0;
    check("R3 level not cleared", {31'd0, status[3]}, 32'd1);

    // R9 push+pop with 1..3 stored
    for (int n = 1; n <= 3; n++) begin
      for (int j = 0; j < n; j++) push(32'h00005500 + j, 0, 0);
      in_valid = 1; in_data = 32'h00007777; pop_req = 1;
      tick();
      in_valid = 0; pop_req = 0;
      check($sformatf("R9 count n=%0d", n), {29'd0, status[2:0]}, n);
      check($sformatf("R11 pushpop head n=%0d", n), {16'd0, sample_q}, 32'h00005500);
      soft_rst = 1; tick(); soft_rst = 0;
    end

    // R7 events and R8 set-wins
    roll_evt = 1; tick(); roll_evt = 0;
    check("R7 rollover", {25'd0, status}, {25'd0, 7'b0011000});
    cmp_evt = 1; tick(); cmp_evt = 0;
    check("R7 compare", {30'd0, status[5:4]}, 32'd3);
    clr_valid = 1; clr_mask = 7'b0110000; cmp_evt = 1;
    tick();
    clr_valid = 0; clr_mask = '0; cmp_evt = 0;
    check("R8 set wins", {30'd0, status[5:4]}, 32'd2);
    clr_valid = 1; clr_mask = 7'b0100000;
    tick();
    clr_valid = 0; clr_mask = '0;
    check("R8 compare cleared", {30'd0, status[5:4]}, 32'd0);

    // R12 soft reset with push blocked
    push(32'h00004242, 0, 0);
    pop();
    push(32'h00001111, 0, 0);
    roll_evt = 1; tick(); roll_evt = 0;
    soft_rst = 1; in_valid = 1; in_data = 32'h00009999;
    tick();
    soft_rst = 0; in_valid = 0;
    check("R12 soft reset status", {25'd0, status}, {25'd0, 7'b0001000});
    check("R12 soft reset sample", {16'd0, sample_q}, 32'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule